// File: doc/BRIEF.md
# Bus-Sizing FIFO with Programmable Flags

This block is a single-clock FIFO. It takes 36-bit words on a write port and hands them out on a read port as whole 36-bit words, as 18-bit halves or as 9-bit bytes. When the read unit is narrower than a word, the word is split into parts. The parts leave either most-significant first or least-significant first. Depth is a power-of-two parameter. The occupancy is kept in stored words. A per-word part counter on the read side tracks how much of the oldest word has been consumed.

Two read timings are offered. In standard timing, the read flag is an empty flag, the write flag is a full flag, and a registered output updates one cycle after a read is accepted. In fall-through timing, the unit at the head is shown on the output as soon as it is stored. The read flag then means output ready and the write flag means input ready. Almost-empty and almost-full flags compare the occupancy against two offsets. The offsets take a default chosen at reset. They can later be replaced by a parallel load or by a serial shift. Read width, part order and timing mode are captured during reset and stay fixed until the next reset.

Top module: `sizing_fifo`

## Requirements
- R1: With rstN low for at least one rising edge, the FIFO comes out of reset empty. In standard timing rdFlag is 1, wrFlag is 0 and rdData is 0. In fall-through timing rdFlag is 0 and wrFlag is 1. almostEmpty is 1 and almostFull is 0.
- R2: The read-width code latched at reset selects the read unit. Codes 0 and 3 select 36-bit units, each a whole stored word, delivered in write order on rdData[35:0].
- R3: Code 1 selects 18-bit units, two per word, on rdData[17:0] with rdData[35:18] at 0. With cfgBigEnd=1, bits [35:18] go first. With cfgBigEnd=0, bits [17:0] go first.
- R4: Code 2 selects 9-bit units, four per word, on rdData[8:0] with the upper bits at 0. With cfgBigEnd=1 the order is [35:27], [26:18], [17:9], [8:0]. With cfgBigEnd=0 it is the reverse.
- R5: Standard timing (cfgFwft=0): rdFlag is an empty flag, 1 when no word is stored. An accepted read puts the next unit on rdData at the rising edge that accepts it. rdData then holds its value until the next accepted read.
- R6: Fall-through timing (cfgFwft=1): the head unit is on rdData while rdFlag is 1. A word written into an empty FIFO shows up on rdData, with rdFlag at 1, right after the write edge and with no read request. A read advances to the next unit.
- R7: When DEPTH words are stored, the FIFO is full. wrFlag is 1 in standard timing and 0 in fall-through timing. A write while full is dropped: the stored words and their order stay unchanged.
- R8: A read while empty is dropped. In standard timing rdData stays unchanged, and the read position does not move, so the next word written is the next one read.
- R9: almostEmpty is 1 exactly when the stored word count is at or below the empty offset. almostFull is 1 exactly when DEPTH minus the count is at or below the full offset. A partly read word still counts as stored.
- R10: At reset both offsets take a default from cfgOffSel: 0 gives 8, 1 gives 16, 2 gives 64, 3 gives 256, 4 gives 1024, and codes 5 to 7 give 8.
- R11: ldAe loads ldValue into the empty offset, and ldAf loads it into the full offset. In a cycle with either load, a serial shift request is ignored.
- R12: With serEn=1 and no load, the concatenation {empty offset, full offset} shifts left by one bit. serBit enters the full offset LSB, and the full offset MSB moves into the empty offset LSB.
- R13: cfgWidth, cfgBigEnd, cfgFwft and cfgOffSel are sampled only while rstN is low. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rstN | input | 1 | Synchronous active-low reset; configuration sampled while low |
| cfgWidth | input | 2 | Read unit code: 0/3 = 36, 1 = 18, 2 = 9 bits |
| cfgBigEnd | input | 1 | 1 = most-significant part first |
| cfgFwft | input | 1 | 1 = fall-through timing, 0 = standard timing |
| cfgOffSel | input | 3 | Default offset code for both almost flags |
| wrEn | input | 1 | Write request |
| wrData | input | 36 | Write word |
| rdEn | input | 1 | Read request for one unit |
| rdData | output | 36 | Read unit, zero-extended |
| rdFlag | output | 1 | Empty (standard) or output ready (fall-through) |
| wrFlag | output | 1 | Full (standard) or input ready (fall-through) |
| almostEmpty | output | 1 | Count at or below empty offset |
| almostFull | output | 1 | Free space at or below full offset |
| ldAe | input | 1 | Parallel load of empty offset |
| ldAf | input | 1 | Parallel load of full offset |
| ldValue | input | OFF_W | Parallel offset value |
| serEn | input | 1 | Serial offset shift enable |
| serBit | input | 1 | Serial offset bit |

## Verification
All flags are decoded from registered pointers. The almost flags, the empty, full and ready flags, and the fall-through output therefore settle right after the rising edge that accepts a write, a read or an offset load. In standard timing rdData changes at the edge that accepts the read. The bench drives every request at a falling edge and samples at the next falling edge, one rising edge later. In fall-through mode the head unit is checked before the read that consumes it. The sweep covers every width, part order and timing mode, and the reset-only inputs are scrambled after each reset.

// File: rtl/sizing_fifo_pkg.sv
package sizing_fifo_pkg;
  localparam int WORD_W = 36;
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = WORD_W / 4;
  localparam int LANES  = WORD_W / BYTE_W;

  typedef enum logic [1:0] {
    BUS_LONG = 2'd0,
    BUS_HALF = 2'd1,
    BUS_BYTE = 2'd2
  } busWidth_e;

  typedef struct packed {
    logic      wrStb;
    logic      capStb;
    logic      fwftSel;
    busWidth_e width;
    logic [1:0] slice;
  } dpStrobe_t;
endpackage

// File: rtl/sizing_fifo_ctrl.sv
module sizing_fifo_ctrl
  import sizing_fifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgWidth,
  input  logic              cfgBigEnd,
  input  logic              cfgFwft,
  input  logic [2:0]        cfgOffSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              ldAe,
  input  logic              ldAf,
  input  logic [OFF_W-1:0]  ldValue,
  input  logic              serEn,
  input  logic              serBit,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output dpStrobe_t         strb,
  output logic              rdFlag,
  output logic              wrFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;
  localparam int CMP_W = (OFF_W > PTR_W) ? OFF_W : PTR_W;

  busWidth_e        widthR;
  logic             bigR, fwftR;
  logic [PTR_W-1:0] wrPtr, rdPtr, count, freeSpace;
  logic [1:0]       partIdx, slice;
  logic [OFF_W-1:0] aeOff, afOff;
  logic             isEmpty, isFull, wrAcc, rdAcc, lastPart;

  function automatic logic [OFF_W-1:0] defaultOff(input logic [2:0] sel);
    case (sel)
      3'd1:    return OFF_W'(16);
      3'd2:    return OFF_W'(64);
      3'd3:    return OFF_W'(256);
      3'd4:    return OFF_W'(1024);
      default: return OFF_W'(8);
    endcase
  endfunction

  always_comb begin
    count     = wrPtr - rdPtr;
    freeSpace = PTR_W'(DEPTH) - count;
    isEmpty   = (count == '0);
    isFull    = (count == PTR_W'(DEPTH));
    wrAcc     = wrEn && !isFull;
    rdAcc     = rdEn && !isEmpty;
    case (widthR)
      BUS_HALF: begin lastPart = partIdx[0];       slice = {1'b0, partIdx[0] ^ bigR}; end
      BUS_BYTE: begin lastPart = (partIdx == 2'd3); slice = bigR ? ~partIdx : partIdx; end
      default:  begin lastPart = 1'b1;             slice = 2'd0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthR  <= (cfgWidth == 2'd3) ? BUS_LONG : busWidth_e'(cfgWidth);
      bigR    <= cfgBigEnd;
      fwftR   <= cfgFwft;
      wrPtr   <= '0;
      rdPtr   <= '0;
      partIdx <= '0;
      aeOff   <= defaultOff(cfgOffSel);
      afOff   <= defaultOff(cfgOffSel);
    end else begin
      if (wrAcc) wrPtr <= wrPtr + 1'b1;
      if (rdAcc) begin
        if (lastPart) begin
          partIdx <= '0;
          rdPtr   <= rdPtr + 1'b1;
        end else begin
          partIdx <= partIdx + 1'b1;
        end
      end
      if (ldAe || ldAf) begin
        if (ldAe) aeOff <= ldValue;
        if (ldAf) afOff <= ldValue;
      end else if (serEn) begin
        {aeOff, afOff} <= {aeOff[OFF_W-2:0], afOff, serBit};
      end
    end
  end

  assign wrAddr       = wrPtr[ADDR_W-1:0];
  assign rdAddr       = rdPtr[ADDR_W-1:0];
  assign strb.wrStb   = wrAcc;
  assign strb.capStb  = rdAcc && !fwftR;
  assign strb.fwftSel = fwftR;
  assign strb.width   = widthR;
  assign strb.slice   = slice;
  assign rdFlag       = fwftR ? !isEmpty : isEmpty;
  assign wrFlag       = fwftR ? !isFull : isFull;
  assign almostEmpty  = CMP_W'(count) <= CMP_W'(aeOff);
  assign almostFull   = CMP_W'(freeSpace) <= CMP_W'(afOff);
endmodule

// File: rtl/sizing_fifo_dpath.sv
module sizing_fifo_dpath
  import sizing_fifo_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] curWord, unitOut, outReg;
  logic [BYTE_W-1:0] lane [LANES];

  always_ff @(posedge clk) begin
    if (strb.wrStb) mem[wrAddr] <= wrData;
  end

  assign curWord = mem[rdAddr];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign lane[g] = curWord[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    case (strb.width)
      BUS_HALF: unitOut = WORD_W'(strb.slice[0] ? curWord[WORD_W-1:HALF_W] : curWord[HALF_W-1:0]);
      BUS_BYTE: unitOut = WORD_W'(lane[strb.slice]);
      default:  unitOut = curWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outReg <= '0;
    else if (strb.capStb) outReg <= unitOut;
  end

  assign rdData = strb.fwftSel ? unitOut : outReg;
endmodule

// File: rtl/sizing_fifo.sv
module sizing_fifo
  import sizing_fifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgWidth,
  input  logic              cfgBigEnd,
  input  logic              cfgFwft,
  input  logic [2:0]        cfgOffSel,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdFlag,
  output logic              wrFlag,
  output logic              almostEmpty,
  output logic              almostFull,
  input  logic              ldAe,
  input  logic              ldAf,
  input  logic [OFF_W-1:0]  ldValue,
  input  logic              serEn,
  input  logic              serBit
);
  dpStrobe_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  sizing_fifo_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgBigEnd(cfgBigEnd),
    .cfgFwft(cfgFwft), .cfgOffSel(cfgOffSel), .wrEn(wrEn), .rdEn(rdEn),
    .ldAe(ldAe), .ldAf(ldAf), .ldValue(ldValue), .serEn(serEn), .serBit(serBit),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .strb(strb), .rdFlag(rdFlag),
    .wrFlag(wrFlag), .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  sizing_fifo_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/sizing_fifo_chk.sv
module sizing_fifo_chk
  import sizing_fifo_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              rdFlag,
  input logic              wrFlag,
  input logic              almostEmpty,
  input logic              almostFull,
  input logic [WORD_W-1:0] rdData,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input dpStrobe_t         strb
);
  logic emptyNow, fullNow;
  assign emptyNow = strb.fwftSel ? !rdFlag : rdFlag;
  assign fullNow  = strb.fwftSel ? !wrFlag : wrFlag;

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (fullNow && wrEn) |=> $stable(wrAddr));

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (emptyNow && rdEn) |=> $stable(rdAddr));

  a_r5_output_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.fwftSel && !strb.capStb) |=> $stable(rdData));

  a_r9_full_is_almost_full: assert property (@(posedge clk) disable iff (!rstN)
    fullNow |-> almostFull);

  a_r9_empty_is_almost_empty: assert property (@(posedge clk) disable iff (!rstN)
    emptyNow |-> almostEmpty);

  a_r13_config_fixed: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($stable(strb.width) && $stable(strb.fwftSel)));
endmodule

bind sizing_fifo sizing_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdFlag(rdFlag),
  .wrFlag(wrFlag), .almostEmpty(almostEmpty), .almostFull(almostFull),
  .rdData(rdData), .wrAddr(wrAddr), .rdAddr(rdAddr), .strb(strb)
);

// File: tb/sim_sizing_fifo.sv
module sim_sizing_fifo;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int OW    = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgWidth = '0;
  logic cfgBigEnd = 1'b0, cfgFwft = 1'b0;
  logic [2:0] cfgOffSel = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [35:0] wrData = '0;
  logic [35:0] rdData;
  logic rdFlag, wrFlag, almostEmpty, almostFull;
  logic ldAe = 1'b0, ldAf = 1'b0, serEn = 1'b0, serBit = 1'b0;
  logic [OW-1:0] ldValue = '0;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sizing_fifo #(.ADDR_W(AW), .OFF_W(OW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgBigEnd(cfgBigEnd),
    .cfgFwft(cfgFwft), .cfgOffSel(cfgOffSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .rdFlag(rdFlag), .wrFlag(wrFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull), .ldAe(ldAe),
    .ldAf(ldAf), .ldValue(ldValue), .serEn(serEn), .serBit(serBit)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] wordOf(input int i);
    return 36'h1_2345_6789 + 36'(i) * 36'h1_1111_1111;
  endfunction

  function automatic int partsOf(input int w);
    return (w == 1) ? 2 : ((w == 2) ? 4 : 1);
  endfunction

  function automatic logic [35:0] expUnit(input logic [35:0] w, input int wsel, input bit big, input int p);
    int n = partsOf(wsel);
    int uw = 36 / n;
    int s = big ? (n - 1 - p) : p;
    logic [63:0] m = (64'd1 << uw) - 64'd1;
    return 36'((64'(w) >> (s * uw)) & m);
  endfunction

  task automatic doReset(input int w, input bit big, input bit fw, input int sel);
    cfgWidth = 2'(w); cfgBigEnd = big; cfgFwft = fw; cfgOffSel = 3'(sel);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    cfgWidth = 2'(w + 1); cfgBigEnd = !big; cfgFwft = !fw; cfgOffSel = 3'(sel + 3);
  endtask

  task automatic wrWord(input logic [35:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdUnit();
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic serShift(input bit b);
    serEn = 1'b1; serBit = b;
    @(negedge clk);
    serEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input bit fw, input logic [35:0] exp);
    if (fw) begin
      check(tag, rdData, exp);
      rdUnit();
    end else begin
      rdUnit();
      check(tag, rdData, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Sweep: every width, part order and timing mode (R1..R6, R13)
    for (int w = 0; w < 3; w++) begin
      for (int big = 0; big < 2; big++) begin
        for (int fw = 0; fw < 2; fw++) begin
          string tag;
          logic [35:0] last;
          tag = (w == 0) ? "R2 R13" : ((w == 1) ? "R3 R13" : "R4 R13");
          doReset(w, big[0], fw[0], 0);
          check("R1 rdFlag", rdFlag, fw ? 0 : 1);
          check("R1 wrFlag", wrFlag, fw ? 1 : 0);
          check("R1 almostEmpty", almostEmpty, 1);
          check("R1 almostFull", almostFull, 0);
          if (fw == 0) check("R1 rdData", rdData, 0);
          wrWord(wordOf(0));
          if (fw != 0) begin
            check("R6 ready after write", rdFlag, 1);
            check("R6 fall-through data", rdData, expUnit(wordOf(0), w, big[0], 0));
          end else begin
            check("R5 output holds before read", rdData, 0);
          end
          wrWord(wordOf(1));
          wrWord(wordOf(2));
          last = '0;
          for (int i = 0; i < 3; i++) begin
            for (int p = 0; p < partsOf(w); p++) begin
              last = expUnit(wordOf(i), w, big[0], p);
              readCheck(tag, fw[0], last);
            end
          end
          if (fw == 0) begin
            @(negedge clk);
            check("R5 output holds idle", rdData, last);
            check("R5 empty flag after drain", rdFlag, 1);
          end else begin
            check("R6 not ready after drain", rdFlag, 0);
          end
        end
      end
    end

    // R7 full, standard timing
    doReset(0, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) wrWord(36'(100 + i));
    check("R7 full flag", wrFlag, 1);
    check("R9 almostFull at full", almostFull, 1);
    wrWord(36'd999);
    for (int i = 0; i < DEPTH; i++) readCheck("R7 data kept", 1'b0, 36'(100 + i));
    check("R7 empty after drain", rdFlag, 1);

    // R7 full, fall-through timing
    doReset(0, 0, 1, 0);
    for (int i = 0; i < DEPTH; i++) wrWord(36'(200 + i));
    check("R7 input not ready", wrFlag, 0);
    wrWord(36'd999);
    for (int i = 0; i < DEPTH; i++) readCheck("R7 data kept fwft", 1'b1, 36'(200 + i));
    check("R7 drained fwft", rdFlag, 0);

    // R8 read while empty
    doReset(0, 0, 0, 0);
    rdUnit();
    check("R8 rdData unchanged", rdData, 0);
    check("R8 still empty", rdFlag, 1);
    wrWord(36'h123);
    readCheck("R8 next word", 1'b0, 36'h123);
    doReset(0, 0, 1, 0);
    rdUnit();
    wrWord(36'h456);
    check("R8 fwft ready", rdFlag, 1);
    readCheck("R8 fwft word", 1'b1, 36'h456);
    check("R8 fwft drained", rdFlag, 0);

    // R9 thresholds against count, default offsets 8/8
    doReset(0, 0, 0, 0);
    for (int c = 1; c <= DEPTH; c++) begin
      wrWord(wordOf(c));
      check("R9 almostEmpty", almostEmpty, (c <= 8) ? 1 : 0);
      check("R9 almostFull", almostFull, ((DEPTH - c) <= 8) ? 1 : 0);
    end
    // R9 partly read word still counted
    doReset(2, 0, 0, 0);
    for (int i = 0; i < 9; i++) wrWord(wordOf(i));
    check("R9 nine words", almostEmpty, 0);
    rdUnit();
    check("R9 partial word counted", almostEmpty, 0);
    repeat (3) rdUnit();
    check("R9 eight words", almostEmpty, 1);

    // R10 defaults via R12 shifting: zeros push own bit out, full-offset bit arrives as 1
    for (int sel = 0; sel < 8; sel++) begin
      int lg;
      lg = (sel == 1) ? 4 : (sel == 2) ? 6 : (sel == 3) ? 8 : (sel == 4) ? 10 : 3;
      doReset(0, 0, 0, sel);
      for (int k = 0; k < OW - lg; k++) serShift(1'b0);
      wrWord(wordOf(0));
      check("R10 R12 offset one at count 1", almostEmpty, 1);
      wrWord(wordOf(1));
      check("R10 R12 offset one at count 2", almostEmpty, 0);
    end

    // R12 serial load: full offset becomes 3, empty offset receives old full offset 8
    doReset(0, 0, 0, 0);
    for (int k = 0; k < OW - 2; k++) serShift(1'b0);
    serShift(1'b1);
    serShift(1'b1);
    for (int c = 1; c <= 13; c++) begin
      wrWord(wordOf(c));
      if (c == 8)  check("R12 ae at 8", almostEmpty, 1);
      if (c == 9)  check("R12 ae at 9", almostEmpty, 0);
      if (c == 12) check("R12 af at 12", almostFull, 0);
      if (c == 13) check("R12 af at 13", almostFull, 1);
    end

    // R11 parallel load with priority over shift
    doReset(0, 0, 0, 0);
    ldAe = 1'b1; ldValue = OW'(5); serEn = 1'b1; serBit = 1'b1;
    @(negedge clk);
    ldAe = 1'b0; serEn = 1'b0; serBit = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      wrWord(wordOf(c));
      if (c == 5) check("R11 ae at 5", almostEmpty, 1);
      if (c == 6) check("R11 ae at 6", almostEmpty, 0);
      if (c == 7) check("R11 af unshifted at 7", almostFull, 0);
      if (c == 8) check("R11 af unshifted at 8", almostFull, 1);
    end
    ldAf = 1'b1; ldValue = OW'(2);
    @(negedge clk);
    ldAf = 1'b0;
    check("R11 af reloaded at 8", almostFull, 0);
    for (int c = 9; c <= 14; c++) begin
      wrWord(wordOf(c));
      if (c == 13) check("R11 af at 13", almostFull, 0);
      if (c == 14) check("R11 af at 14", almostFull, 1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule